// File: doc/BRIEF.md
# Exception Status Save/Restore Stack

This unit keeps a processor core's status flags and return addresses across exceptions. It has three status levels: live, backup and second-level backup. Each level holds three flags: a mode flag, an interrupt-enable flag and a condition flag. It also has two return-address levels: a backup PC and a second-level backup PC. Software reaches all of these through a control-register move port. The port takes a register index, write data and a write strobe, and returns read data in the same cycle.

The unit moves its stack in two directions. An exception-entry strobe pushes it: each status level moves one step deeper, the faulting PC goes into the backup PC, and the live mode and interrupt-enable flags are cleared. A return strobe pops it: the live status takes the backup status, and the backup status takes the second-level copy, which keeps its value. The backup PC takes the second-level backup PC, which also keeps its value. While the pop happens, the unit drives the return target: the backup PC rounded down to a 4-byte boundary. Instruction decode, the pipeline, the register file and interrupt arbitration are all outside this block.

Top module: `exc_status_stack`

## Requirements
- R1: Index 0 is the status word. Live status uses bit 7 (mode), bit 6 (interrupt enable) and bit 0 (condition). Backup status uses bit 15 (mode), bit 14 (interrupt enable) and bit 8 (condition). A write stores exactly these six bits, and every other bit of index 0 reads as zero.
- R2: Index 8 is the second-level backup status. It uses bit 7 (mode), bit 6 (interrupt enable) and bit 0 (condition). Every other bit reads as zero.
- R3: Index 6 is the backup PC and index 10 is the second-level backup PC. Both are full-width read/write registers. Every other index reads as zero, and writes to it change no register.
- R4: On a return strobe, the live status takes the backup status, the backup status takes the second-level backup, and the second-level backup keeps its value.
- R5: On a return strobe, the backup PC takes the second-level backup PC, and the second-level backup PC keeps its value.
- R6: The return-target output always equals the current backup PC with bits 1:0 forced to zero. For example, a backup PC of 0x2002 gives 0x2000.
- R7: On an exception strobe, the second-level backup status takes the backup status and the backup status takes the live status. The live mode and interrupt-enable flags clear, and the live condition flag is kept. The second-level backup PC takes the backup PC, and the backup PC takes the current PC input.
- R8: If a control-register write and a return strobe arrive in the same cycle, the return is performed and the write is dropped.
- R9: If an exception strobe arrives together with a return strobe or a write, only the exception push is performed.
- R10: Synchronous reset clears all three status levels and both backup PCs to zero.
- R11: Read data is combinational from the index. A write is visible in the read data from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cr_idx | input | 4 | Control-register index for read and write |
| cr_wr | input | 1 | Control-register write strobe |
| cr_wdata | input | 32 | Control-register write data |
| cr_rdata | output | 32 | Control-register read data |
| rte_strobe | input | 1 | Return-from-exception strobe |
| exc_strobe | input | 1 | Exception-entry strobe |
| cur_pc | input | 32 | PC of the faulting instruction |
| ret_pc | output | 32 | Return target, word aligned |

## Verification
The checker examines every cycle. After each pop it confirms that the status levels and PCs moved one step and that the second-level copies held (R4, R5). After each push it confirms the full push (R7), which also covers the case where an exception arrives together with a return. It also checks that the return target stays word aligned, that the unused bits of the status word read as zero, and that reset clears every level. Some behaviours only the bench's scenarios can show: the exact bit layout through write and read-back, that writes to unused indices are ignored, that a write collides with a return and loses, and the two pop sequences with their concrete values.

// File: rtl/exc_stack_pkg.sv
package exc_stack_pkg;

    localparam int XLEN     = 32;
    localparam int CR_IDX_W = 4;

    localparam logic [CR_IDX_W-1:0] IDX_STAT  = 4'd0;
    localparam logic [CR_IDX_W-1:0] IDX_BPC   = 4'd6;
    localparam logic [CR_IDX_W-1:0] IDX_STAT2 = 4'd8;
    localparam logic [CR_IDX_W-1:0] IDX_BPC2  = 4'd10;

    // Field positions within a 16-bit status image
    localparam int POS_MODE = 7;
    localparam int POS_IEN  = 6;
    localparam int POS_COND = 0;
    localparam int HI_OFS   = 8;

    localparam int PC_ALIGN_BITS = 2;

    typedef struct packed {
        logic mode;
        logic ien;
        logic cond;
    } flags_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_WRITE,
        OP_RETURN,
        OP_ENTER
    } stack_op_t;

    localparam flags_t FLAGS_ZERO = '{mode: 1'b0, ien: 1'b0, cond: 1'b0};

    // Exception beats return, return beats a register write
    function automatic stack_op_t pick_op(input logic exc, input logic rte, input logic wr);
        if (exc)      return OP_ENTER;
        else if (rte) return OP_RETURN;
        else if (wr)  return OP_WRITE;
        else          return OP_IDLE;
    endfunction

    function automatic flags_t flags_from_byte(input logic [7:0] b);
        flags_t f;
        f.mode = b[POS_MODE];
        f.ien  = b[POS_IEN];
        f.cond = b[POS_COND];
        return f;
    endfunction

    function automatic logic [7:0] flags_to_byte(input flags_t f);
        logic [7:0] b;
        b = '0;
        b[POS_MODE] = f.mode;
        b[POS_IEN]  = f.ien;
        b[POS_COND] = f.cond;
        return b;
    endfunction

    function automatic flags_t flags_on_entry(input flags_t live);
        flags_t f;
        f.mode = 1'b0;
        f.ien  = 1'b0;
        f.cond = live.cond;
        return f;
    endfunction

endpackage

// File: rtl/exc_flag_levels.sv
module exc_flag_levels
    import exc_stack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  stack_op_t  op,
    input  logic       sel_stat,
    input  logic       sel_stat2,
    input  logic [15:0] wimage,
    output flags_t     live_q,
    output flags_t     back_q,
    output flags_t     back2_q
);

    flags_t w_lo, w_hi;

    always_comb begin
        w_lo = flags_from_byte(wimage[7:0]);
        w_hi = flags_from_byte(wimage[15:HI_OFS]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= FLAGS_ZERO;
            back_q  <= FLAGS_ZERO;
            back2_q <= FLAGS_ZERO;
        end else begin
            unique case (op)
                OP_ENTER: begin
                    back2_q <= back_q;
                    back_q  <= live_q;
                    live_q  <= flags_on_entry(live_q);
                end
                OP_RETURN: begin
                    live_q <= back_q;
                    back_q <= back2_q;
                end
                OP_WRITE: begin
                    if (sel_stat) begin
                        live_q <= w_lo;
                        back_q <= w_hi;
                    end
                    if (sel_stat2) begin
                        back2_q <= w_lo;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/exc_pc_levels.sv
module exc_pc_levels
    import exc_stack_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  stack_op_t    op,
    input  logic         sel_bpc,
    input  logic         sel_bpc2,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] fault_pc,
    output logic [W-1:0] bpc_q,
    output logic [W-1:0] bpc2_q,
    output logic [W-1:0] target
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bpc_q  <= '0;
            bpc2_q <= '0;
        end else begin
            unique case (op)
                OP_ENTER: begin
                    bpc2_q <= bpc_q;
                    bpc_q  <= fault_pc;
                end
                OP_RETURN: begin
                    bpc_q <= bpc2_q;
                end
                OP_WRITE: begin
                    if (sel_bpc)  bpc_q  <= wdata;
                    if (sel_bpc2) bpc2_q <= wdata;
                end
                default: ;
            endcase
        end
    end

    assign target = {bpc_q[W-1:PC_ALIGN_BITS], {PC_ALIGN_BITS{1'b0}}};

endmodule

// File: rtl/exc_cr_readmux.sv
module exc_cr_readmux
    import exc_stack_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [CR_IDX_W-1:0] idx,
    input  flags_t              live,
    input  flags_t              back,
    input  flags_t              back2,
    input  logic [W-1:0]        bpc,
    input  logic [W-1:0]        bpc2,
    output logic [W-1:0]        rdata
);

    localparam int PAD = W - 16;

    logic [15:0] stat_img, stat2_img;

    always_comb begin
        stat_img  = {flags_to_byte(back), flags_to_byte(live)};
        stat2_img = {8'h00, flags_to_byte(back2)};
    end

    generate
        if (PAD > 0) begin : g_pad
            always_comb begin
                unique case (idx)
                    IDX_STAT:  rdata = {{PAD{1'b0}}, stat_img};
                    IDX_STAT2: rdata = {{PAD{1'b0}}, stat2_img};
                    IDX_BPC:   rdata = bpc;
                    IDX_BPC2:  rdata = bpc2;
                    default:   rdata = '0;
                endcase
            end
        end else begin : g_nopad
            always_comb begin
                unique case (idx)
                    IDX_STAT:  rdata = stat_img;
                    IDX_STAT2: rdata = stat2_img;
                    IDX_BPC:   rdata = bpc;
                    IDX_BPC2:  rdata = bpc2;
                    default:   rdata = '0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
    import exc_stack_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [CR_IDX_W-1:0] cr_idx,
    input  logic                cr_wr,
    input  logic [XLEN-1:0]     cr_wdata,
    output logic [XLEN-1:0]     cr_rdata,
    input  logic                rte_strobe,
    input  logic                exc_strobe,
    input  logic [XLEN-1:0]     cur_pc,
    output logic [XLEN-1:0]     ret_pc
);

    stack_op_t op;
    flags_t    live_q, back_q, back2_q;
    logic [XLEN-1:0] bpc_q, bpc2_q;
    logic sel_stat, sel_stat2, sel_bpc, sel_bpc2;

    always_comb begin
        op        = pick_op(exc_strobe, rte_strobe, cr_wr);
        sel_stat  = (cr_idx == IDX_STAT);
        sel_stat2 = (cr_idx == IDX_STAT2);
        sel_bpc   = (cr_idx == IDX_BPC);
        sel_bpc2  = (cr_idx == IDX_BPC2);
    end

    exc_flag_levels u_flags (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .sel_stat  (sel_stat),
        .sel_stat2 (sel_stat2),
        .wimage    (cr_wdata[15:0]),
        .live_q    (live_q),
        .back_q    (back_q),
        .back2_q   (back2_q)
    );

    exc_pc_levels #(.W(XLEN)) u_pcs (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .sel_bpc  (sel_bpc),
        .sel_bpc2 (sel_bpc2),
        .wdata    (cr_wdata),
        .fault_pc (cur_pc),
        .bpc_q    (bpc_q),
        .bpc2_q   (bpc2_q),
        .target   (ret_pc)
    );

    exc_cr_readmux #(.W(XLEN)) u_rd (
        .idx   (cr_idx),
        .live  (live_q),
        .back  (back_q),
        .back2 (back2_q),
        .bpc   (bpc_q),
        .bpc2  (bpc2_q),
        .rdata (cr_rdata)
    );

endmodule

// File: rtl/exc_status_stack_chk.sv
module exc_status_stack_chk
    import exc_stack_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [CR_IDX_W-1:0] cr_idx,
    input logic [XLEN-1:0]     cr_rdata,
    input logic                rte_strobe,
    input logic                exc_strobe,
    input logic [XLEN-1:0]     cur_pc,
    input logic [XLEN-1:0]     ret_pc,
    input flags_t              live_q,
    input flags_t              back_q,
    input flags_t              back2_q,
    input logic [XLEN-1:0]     bpc_q,
    input logic [XLEN-1:0]     bpc2_q
);

    AST_RTE_LIVE: assert property (@(posedge clk) disable iff (rst)
        (rte_strobe && !exc_strobe) |=> live_q == $past(back_q)); // R4
    AST_RTE_BACK: assert property (@(posedge clk) disable iff (rst)
        (rte_strobe && !exc_strobe) |=> back_q == $past(back2_q)); // R4
    AST_RTE_BACK2_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rte_strobe && !exc_strobe) |=> $stable(back2_q)); // R4
    AST_RTE_BPC: assert property (@(posedge clk) disable iff (rst)
        (rte_strobe && !exc_strobe) |=> (bpc_q == $past(bpc2_q)) && $stable(bpc2_q)); // R5
    AST_RET_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (ret_pc[1:0] == 2'b00) && (ret_pc[XLEN-1:2] == bpc_q[XLEN-1:2])); // R6
    AST_EXC_PUSH: assert property (@(posedge clk) disable iff (rst)
        exc_strobe |=> (back2_q == $past(back_q)) && (back_q == $past(live_q))
                       && !live_q.mode && !live_q.ien && (live_q.cond == $past(live_q.cond))
                       && (bpc_q == $past(cur_pc)) && (bpc2_q == $past(bpc_q))); // R7
    AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cr_idx == IDX_STAT) |-> (cr_rdata[XLEN-1:16] == '0) && (cr_rdata[13:9] == '0)
                                 && (cr_rdata[5:1] == '0)); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (live_q == FLAGS_ZERO) && (back_q == FLAGS_ZERO) && (back2_q == FLAGS_ZERO)
                && (bpc_q == '0) && (bpc2_q == '0)); // R10

endmodule

bind exc_status_stack exc_status_stack_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cr_idx     (cr_idx),
    .cr_rdata   (cr_rdata),
    .rte_strobe (rte_strobe),
    .exc_strobe (exc_strobe),
    .cur_pc     (cur_pc),
    .ret_pc     (ret_pc),
    .live_q     (live_q),
    .back_q     (back_q),
    .back2_q    (back2_q),
    .bpc_q      (bpc_q),
    .bpc2_q     (bpc2_q)
);

// File: tb/test_exc_status_stack.sv
module test_exc_status_stack;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [3:0]  idx;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{4'd0,  32'hFFFF_FFFF, 32'h0000_C1C1},
        '{4'd0,  32'h0000_C100, 32'h0000_C100},
        '{4'd0,  32'h0000_00C1, 32'h0000_00C1},
        '{4'd0,  32'h1234_5678, 32'h0000_4040},
        '{4'd0,  32'h0000_8001, 32'h0000_8001},
        '{4'd0,  32'h0000_4140, 32'h0000_4140},
        '{4'd8,  32'hFFFF_FFFF, 32'h0000_00C1},
        '{4'd8,  32'h0000_C100, 32'h0000_0000},
        '{4'd6,  32'hDEAD_BEEF, 32'hDEAD_BEEF},
        '{4'd10, 32'h1234_5679, 32'h1234_5679},
        '{4'd3,  32'hFFFF_FFFF, 32'h0000_0000},
        '{4'd15, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cr_idx = '0;
    logic        cr_wr = 1'b0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        rte_strobe = 1'b0;
    logic        exc_strobe = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [31:0] ret_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_status_stack i_exc_status_stack (
        .clk        (clk),
        .rst        (rst),
        .cr_idx     (cr_idx),
        .cr_wr      (cr_wr),
        .cr_wdata   (cr_wdata),
        .cr_rdata   (cr_rdata),
        .rte_strobe (rte_strobe),
        .exc_strobe (exc_strobe),
        .cur_pc     (cur_pc),
        .ret_pc     (ret_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic expect_cr(input string req, input logic [3:0] idx, input logic [31:0] exp);
        @(negedge clk);
        cr_idx = idx;
        #1;
        check(req, cr_rdata, exp);
    endtask

    task automatic cr_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        cr_idx = idx; cr_wdata = d; cr_wr = 1'b1;
        @(negedge clk);
        cr_wr = 1'b0;
    endtask

    task automatic pulse(input logic do_rte, input logic do_exc, input logic do_wr);
        @(negedge clk);
        rte_strobe = do_rte; exc_strobe = do_exc; cr_wr = do_wr;
        @(negedge clk);
        rte_strobe = 1'b0; exc_strobe = 1'b0; cr_wr = 1'b0;
    endtask

    function automatic string req_of(input logic [3:0] idx);
        if (idx == 4'd0) return "R1";
        if (idx == 4'd8) return "R2";
        return "R3";
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        expect_cr("R10", 4'd0, 32'h0);
        expect_cr("R10", 4'd8, 32'h0);
        expect_cr("R10", 4'd6, 32'h0);
        expect_cr("R10", 4'd10, 32'h0);
        check("R10", ret_pc, 32'h0);

        // Table: write then read back on the next cycle (R11)
        for (int i = 0; i < NVEC; i++) begin
            cr_write(VECS[i].idx, VECS[i].wd);
            expect_cr({req_of(VECS[i].idx), "/R11"}, VECS[i].idx, VECS[i].exp);
        end

        // R3 writes to unused indices left every register intact
        expect_cr("R3", 4'd0, 32'h0000_4140);
        expect_cr("R3", 4'd8, 32'h0);
        expect_cr("R3", 4'd6, 32'hDEAD_BEEF);
        expect_cr("R3", 4'd10, 32'h1234_5679);

        // Pop scenario one
        cr_write(4'd8, 32'h0);
        cr_write(4'd0, 32'h0000_C100);
        cr_write(4'd10, 32'h0);
        cr_write(4'd6, 32'h0000_1000);
        check("R6", ret_pc, 32'h0000_1000);
        pulse(1'b1, 1'b0, 1'b0);
        expect_cr("R4", 4'd8, 32'h0);
        expect_cr("R4", 4'd0, 32'h0000_00C1);
        expect_cr("R5", 4'd10, 32'h0);
        expect_cr("R5", 4'd6, 32'h0);

        // Pop scenario two, misaligned backup PC
        cr_write(4'd8, 32'h0000_00C1);
        cr_write(4'd0, 32'h0000_00C1);
        cr_write(4'd10, 32'd42);
        cr_write(4'd6, 32'h0000_2002);
        check("R6", ret_pc, 32'h0000_2000);
        pulse(1'b1, 1'b0, 1'b0);
        expect_cr("R4", 4'd8, 32'h0000_00C1);
        expect_cr("R4", 4'd0, 32'h0000_C100);
        expect_cr("R5", 4'd10, 32'd42);
        expect_cr("R5", 4'd6, 32'd42);
        check("R6", ret_pc, 32'd40);

        // Push
        cr_write(4'd0, 32'h0000_00C1);
        cr_write(4'd8, 32'h0);
        cr_write(4'd6, 32'h0000_0100);
        cr_write(4'd10, 32'h0000_0200);
        cur_pc = 32'h0000_3004;
        pulse(1'b0, 1'b1, 1'b0);
        expect_cr("R7", 4'd0, 32'h0000_C101);
        expect_cr("R7", 4'd8, 32'h0);
        expect_cr("R7", 4'd6, 32'h0000_3004);
        expect_cr("R7", 4'd10, 32'h0000_0100);

        // R8 return and write together: return wins
        cr_write(4'd0, 32'h0000_C100);
        cr_write(4'd8, 32'h0);
        @(negedge clk);
        cr_idx = 4'd0; cr_wdata = 32'h0;
        pulse(1'b1, 1'b0, 1'b1);
        expect_cr("R8", 4'd0, 32'h0000_00C1);

        // R9 exception with return and write: exception only
        cr_write(4'd0, 32'h0000_00C1);
        cr_write(4'd8, 32'h0000_00C1);
        @(negedge clk);
        cr_idx = 4'd8; cr_wdata = 32'h0000_00C1;
        pulse(1'b1, 1'b1, 1'b1);
        expect_cr("R9", 4'd0, 32'h0000_C101);
        expect_cr("R9", 4'd8, 32'h0);

        // R10 reset in mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_cr("R10", 4'd0, 32'h0);
        expect_cr("R10", 4'd6, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule